// File: doc/BRIEF.md
# Audio Codec Core Clock Divider

This block turns one of two selectable source clocks into the constant-rate core clock of an audio codec, plus an optional slower master clock output. Software writes one 8-bit control word. That word picks the source: the external master clock or the PLL clock, which runs at 1024 × fS. It also sets the integer divide (1, 2, 3 or 4) that brings the source down to 256 × fS. The same word turns the core clock on or off, turns the output clock on or off, and sets the output clock's rate.

All logic runs on the single fabric clock `clk_i`. Each source clock arrives as a one-cycle tick strobe (`ext_tick_i`, `pll_tick_i`), with one tick per source clock period. The block emits a registered core tick strobe and an output tick strobe. Next to each strobe is a registered level that changes state once per tick, so each of its edges marks one tick. A new divide ratio, source or output rate waits for the current divider period to finish before it takes effect, so no shortened period is ever produced.

Top module: `acodec_clkdiv`

## Requirements
- R1: The control word resets to 0x00. A write loads bits [6:0] as: output rate [6:5], output enable [4], source select [3], input ratio [2:1], core enable [0]. Bit 7 always reads 0 and writing it has no effect. `rd_data_o` shows the stored word from the cycle after the write.
- R2: Input ratio code k (00, 01, 10, 11) divides the selected source by k+1. Over 96 source ticks the core produces 96, 48, 32 or 24 ticks.
- R3: Source select 0 counts `ext_tick_i` only. Source select 1 counts `pll_tick_i` only. Ticks on the unselected input are ignored.
- R4: `cfg_err_o` is 1 exactly when source select is 1 and the input ratio is not 11.
- R5: Output rate code 00, 01, 10, 11 gives one output tick per 8, 4, 2, 1 core ticks (32, 64, 128, 256 × fS).
- R6: While output enable is 0, `mck_o` is held low and `mck_stb_o` stays 0.
- R7: While core enable is 0, no core or output ticks occur and `core_clk_o` and `mck_o` are low.
- R8: A change of input ratio, source or output rate is applied only at the end of the divider period in progress. For example, after a switch from divide-by-4 to divide-by-1 written right after a core tick, the next core tick still comes 4 source ticks later.
- R9: `core_clk_o` changes level only in a cycle where `core_stb_o` is 1, and it changes in every such cycle. `mck_o` behaves the same way with `mck_stb_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word write data |
| rd_data_o | output | 8 | Stored control word, bit 7 reads 0 |
| ext_tick_i | input | 1 | One pulse per external master clock period |
| pll_tick_i | input | 1 | One pulse per PLL clock period |
| core_stb_o | output | 1 | Core tick strobe (256 × fS) |
| core_clk_o | output | 1 | Core clock level, changes on each core tick |
| mck_stb_o | output | 1 | Output clock tick strobe |
| mck_o | output | 1 | Output clock level, changes on each output tick |
| cfg_err_o | output | 1 | PLL source with an input ratio other than 11 |

## Verification
A table covers every input ratio with the external source and every output rate with the PLL source. For each row, core edges, core strobes and output edges are counted over 96 source ticks. That window is a whole number of periods for every setting, so the counts are exact and separate divide-by-3 from its neighbours. In each row only the selected source runs, which shows that the unselected tick input is ignored. Directed tests cover the reserved bit, the configuration-error combinations, core and output disable, a starved PLL source, and the tick gap across a mid-period ratio change, which separates a deferred switch from an immediate one.

// File: rtl/acodec_clkdiv_pkg.sv
`timescale 1ns/1ps
package acodec_clkdiv_pkg;
  localparam int RATIO_W = 2;
  localparam int RATE_W  = 2;
  localparam int REG_W   = 8;

  typedef struct packed {
    logic [RATE_W-1:0]  rate;
    logic               oen;
    logic               src;
    logic [RATIO_W-1:0] ratio;
    logic               cen;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/acodec_clkdiv_reg.sv
`timescale 1ns/1ps
module acodec_clkdiv_reg
  import acodec_clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output ctrl_t            ctrl_o,
  output logic [REG_W-1:0] rd_data_o,
  output logic             cfg_err_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  assign ctrl_o    = ctrl_q;
  assign rd_data_o = REG_W'(ctrl_q);
  // pll source demands the top ratio code
  assign cfg_err_o = ctrl_q.src && (ctrl_q.ratio != '1);

  AST_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == REG_W'($past(wr_data_i[CTRL_W-1:0]))); // R1
endmodule

// File: rtl/acodec_clkdiv_core.sv
`timescale 1ns/1ps
module acodec_clkdiv_core #(
  parameter int RATIO_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cen_i,
  input  logic               src_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               ext_tick_i,
  input  logic               pll_tick_i,
  output logic               stb_o,
  output logic               clk_o
);
  logic               act_src_q;
  logic [RATIO_W-1:0] act_ratio_q;
  logic [RATIO_W-1:0] cnt_q;
  logic               stb_q;
  logic               clk_q;
  logic               tick;
  logic               term;

  assign tick = act_src_q ? pll_tick_i : ext_tick_i;
  assign term = (cnt_q == act_ratio_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_src_q   <= 1'b0;
      act_ratio_q <= '0;
      cnt_q       <= '0;
      stb_q       <= 1'b0;
      clk_q       <= 1'b0;
    end else if (!cen_i) begin
      // stopped: track config so the restart uses it at once
      act_src_q   <= src_i;
      act_ratio_q <= ratio_i;
      cnt_q       <= '0;
      stb_q       <= 1'b0;
      clk_q       <= 1'b0;
    end else begin
      stb_q <= tick && term;
      if (tick) begin
        if (term) begin
          cnt_q       <= '0;
          act_src_q   <= src_i;
          act_ratio_q <= ratio_i;
          clk_q       <= ~clk_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign stb_o = stb_q;
  assign clk_o = clk_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_ratio_q); // R2
  AST_STB_FROM_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> $past(tick)); // R3
  AST_CORE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cen_i |=> (!stb_q && !clk_q)); // R7
  AST_HOLD_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cen_i) && !$past(tick && term)) |-> ($stable(act_ratio_q) && $stable(act_src_q))); // R8
  AST_CORE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cen_i) && (clk_q != $past(clk_q))) |-> stb_q); // R9
endmodule

// File: rtl/acodec_clkdiv_out.sv
`timescale 1ns/1ps
module acodec_clkdiv_out #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] rate_i,
  input  logic             core_stb_i,
  output logic             stb_o,
  output logic             clk_o
);
  localparam int CNT_W = (2 ** SEL_W) - 1;
  localparam int NSEL  = 2 ** SEL_W;

  logic [SEL_W-1:0] act_rate_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             stb_q;
  logic             clk_q;
  logic             term;

  // rate code i -> period of 2^(CNT_W-i) core ticks
  always_comb begin
    last = '0;
    for (int i = 0; i < NSEL; i++) begin
      if (act_rate_q == SEL_W'(i)) last = CNT_W'((1 << (CNT_W - i)) - 1);
    end
  end

  assign term = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_rate_q <= '0;
      cnt_q      <= '0;
      stb_q      <= 1'b0;
      clk_q      <= 1'b0;
    end else if (!en_i) begin
      act_rate_q <= rate_i;
      cnt_q      <= '0;
      stb_q      <= 1'b0;
      clk_q      <= 1'b0;
    end else begin
      stb_q <= core_stb_i && term;
      if (core_stb_i) begin
        if (term) begin
          cnt_q      <= '0;
          act_rate_q <= rate_i;
          clk_q      <= ~clk_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign stb_o = stb_q;
  assign clk_o = clk_q;

  AST_OUT_FROM_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> $past(core_stb_i)); // R5
  AST_OUT_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last); // R5
  AST_OUT_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!clk_q && !stb_q)); // R6
  AST_OUT_HOLD_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$past(core_stb_i && term)) |-> $stable(act_rate_q)); // R8
  AST_OUT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (clk_q != $past(clk_q))) |-> stb_q); // R9
endmodule

// File: rtl/acodec_clkdiv.sv
`timescale 1ns/1ps
module acodec_clkdiv
  import acodec_clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             ext_tick_i,
  input  logic             pll_tick_i,
  output logic             core_stb_o,
  output logic             core_clk_o,
  output logic             mck_stb_o,
  output logic             mck_o,
  output logic             cfg_err_o
);
  ctrl_t ctrl;

  acodec_clkdiv_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl),
    .rd_data_o (rd_data_o),
    .cfg_err_o (cfg_err_o)
  );

  acodec_clkdiv_core #(.RATIO_W(RATIO_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cen_i      (ctrl.cen),
    .src_i      (ctrl.src),
    .ratio_i    (ctrl.ratio),
    .ext_tick_i (ext_tick_i),
    .pll_tick_i (pll_tick_i),
    .stb_o      (core_stb_o),
    .clk_o      (core_clk_o)
  );

  acodec_clkdiv_out #(.SEL_W(RATE_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl.oen && ctrl.cen),
    .rate_i     (ctrl.rate),
    .core_stb_i (core_stb_o),
    .stb_o      (mck_stb_o),
    .clk_o      (mck_o)
  );
endmodule

// File: tb/sim_acodec_clkdiv.sv
`timescale 1ns/1ps
module sim_acodec_clkdiv;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic ext_run = 1'b1, pll_run = 1'b1, phase = 1'b0;
  logic ext_tick, pll_tick;
  logic core_stb, core_clk, mck_stb, mck, cfg_err;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) phase <= #1 ~phase;
  assign ext_tick = ext_run & phase;
  assign pll_tick = pll_run & phase;

  acodec_clkdiv u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .ext_tick_i(ext_tick), .pll_tick_i(pll_tick),
    .core_stb_o(core_stb), .core_clk_o(core_clk), .mck_stb_o(mck_stb),
    .mck_o(mck), .cfg_err_o(cfg_err)
  );

  // {wdata, core edges per 96 ticks, output edges per 96 ticks}
  // wdata = {rsv, rate[1:0], oen, src, ratio[1:0], cen}
  localparam logic [23:0] VEC [16] = '{
    {1'b0,2'd0,1'b1,1'b0,2'd0,1'b1, 8'd96, 8'd12},
    {1'b0,2'd3,1'b1,1'b0,2'd0,1'b1, 8'd96, 8'd96},
    {1'b0,2'd1,1'b1,1'b0,2'd1,1'b1, 8'd48, 8'd12},
    {1'b0,2'd2,1'b1,1'b0,2'd1,1'b1, 8'd48, 8'd24},
    {1'b0,2'd0,1'b1,1'b0,2'd2,1'b1, 8'd32, 8'd4},
    {1'b0,2'd1,1'b1,1'b0,2'd2,1'b1, 8'd32, 8'd8},
    {1'b0,2'd2,1'b1,1'b0,2'd2,1'b1, 8'd32, 8'd16},
    {1'b0,2'd3,1'b1,1'b0,2'd2,1'b1, 8'd32, 8'd32},
    {1'b0,2'd0,1'b1,1'b0,2'd3,1'b1, 8'd24, 8'd3},
    {1'b0,2'd3,1'b1,1'b0,2'd3,1'b1, 8'd24, 8'd24},
    {1'b0,2'd3,1'b0,1'b0,2'd1,1'b1, 8'd48, 8'd0},
    {1'b0,2'd0,1'b1,1'b1,2'd3,1'b1, 8'd24, 8'd3},
    {1'b0,2'd1,1'b1,1'b1,2'd3,1'b1, 8'd24, 8'd6},
    {1'b0,2'd2,1'b1,1'b1,2'd3,1'b1, 8'd24, 8'd12},
    {1'b0,2'd3,1'b1,1'b1,2'd3,1'b1, 8'd24, 8'd24},
    {1'b0,2'd2,1'b0,1'b1,2'd3,1'b1, 8'd24, 8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // 96 source ticks = 192 fabric cycles
  task automatic measure(output int ce, output int cs, output int me);
    logic pc, pm;
    ce = 0; cs = 0; me = 0;
    @(negedge clk); pc = core_clk; pm = mck;
    for (int k = 0; k < 192; k++) begin
      @(negedge clk);
      if (core_clk != pc) ce++;
      if (core_stb) cs++;
      if (mck != pm) me++;
      pc = core_clk; pm = mck;
    end
  endtask

  task automatic gap(output int n);
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (ext_tick) n++;
      if (core_stb) break;
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    int ce, cs, me, n;
    repeat (3) @(negedge clk);
    // R1, R7: reset state
    check("R1 reset rd_data", rd_data, 0);
    check("R7 reset core_clk", core_clk, 0);
    check("R6 reset mck", mck, 0);
    check("R4 reset cfg_err", cfg_err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 core off no strobe", core_stb, 0);

    // R1: reserved bit
    write_reg(8'hFF);
    check("R1 reserved bit reads 0", rd_data, 8'h7F);
    check("R4 pll with ratio 11", cfg_err, 0);
    write_reg(8'h89);
    check("R1 bit7 ignored", rd_data, 8'h09);
    check("R4 pll with ratio 00", cfg_err, 1);
    write_reg(8'h0B);
    check("R4 pll with ratio 01", cfg_err, 1);
    write_reg(8'h05);
    check("R4 ext with ratio 10", cfg_err, 0);

    // table: R2 R3 R5 R6 R9
    for (int i = 0; i < 16; i++) begin
      ext_run = 1'b1; pll_run = 1'b1;
      write_reg(VEC[i][23:16]);
      repeat (100) @(negedge clk);
      ext_run = !VEC[i][19];
      pll_run = VEC[i][19];
      repeat (4) @(negedge clk);
      measure(ce, cs, me);
      check($sformatf("R2/R3 row %0d core edges", i), ce, int'(VEC[i][15:8]));
      check($sformatf("R9 row %0d core strobes", i), cs, int'(VEC[i][15:8]));
      check($sformatf("R5/R6 row %0d output edges", i), me, int'(VEC[i][7:0]));
    end

    // R3: pll selected but stopped, ext running
    ext_run = 1'b1; pll_run = 1'b1;
    write_reg(8'h1F);
    repeat (100) @(negedge clk);
    pll_run = 1'b0;
    repeat (4) @(negedge clk);
    measure(ce, cs, me);
    check("R3 ext ticks ignored on pll source", ce, 0);
    pll_run = 1'b1;

    // R7: core disabled
    write_reg(8'h16);
    repeat (4) @(negedge clk);
    measure(ce, cs, me);
    check("R7 core edges while off", ce, 0);
    check("R7 output edges while off", me, 0);
    check("R7 core_clk low", core_clk, 0);
    check("R6 mck low", mck, 0);

    // R8: ratio change waits for terminal count
    write_reg(8'h07);
    repeat (100) @(negedge clk);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (core_stb) break;
    end
    wr_en = 1'b1; wr_data = 8'h01;
    gap(n);
    check("R8 old period kept after write", n, 4);
    gap(n);
    check("R8 new period after terminal", n, 1);

    report();
    $finish;
  end
endmodule